// File: doc/BRIEF.md
# Byte-Commanded Integer Accumulator Coprocessor

This block is a small integer engine that sits on the I/O bus of an 8- or 16-bit host. The host never moves a 32-bit operand across the bus. It writes one byte to a command address instead. The address picks the operation. Depending on the command, the byte names one of 256 internal 32-bit registers, gives a literal (a shift count, a carry value or a byte to push), or is ignored. Every operation works between a single 32-bit accumulator and the named register, and it finishes in the clock in which the write is taken.

The register file holds working values and constants such as 0 or 1. To seed a value, the host pushes bytes into the accumulator and stores it to a register. Four status flags (carry, zero, negative, overflow) and the four accumulator bytes are read back through a small combinational read port. Carry follows the no-borrow convention: a subtract leaves C=1 when no borrow occurred, and subtract-with-borrow takes away the inverted carry.

Top module: `int_accum_cop`

## Requirements
- R1: After reset the accumulator reads 0 and all four flags read 0.
- R2: Command 0x00 copies register[data] into A. Command 0x01 copies A into register[data] and leaves A unchanged. Command 0x02 exchanges A and register[data] within one command. 0x00 and 0x02 update Z and N from the new A.
- R3: Command 0x03 computes A+R and command 0x04 computes A+R+C. Both set C to the carry out of bit 31, V to signed overflow, Z when the result is 0, and N to bit 31.
- R4: Command 0x05 computes A-R, command 0x06 computes A-R-(1-C), and command 0x07 computes R-A. C=1 means no borrow. V is signed overflow. Z and N follow the result.
- R5: Command 0x09 sets all four flags exactly as 0x05 would, and A is unchanged.
- R6: Command 0x0A sets A to -A (two's complement). It sets C when the old A was nonzero, V when the old A was 0x80000000, and Z and N from the result.
- R7: Commands 0x0B, 0x0C and 0x0D set A to A AND R, A OR R and A XOR R. They update Z and N and keep C and V.
- R8: Commands 0x0E (left), 0x0F (logical right) and 0x10 (arithmetic right) shift A by data[4:0]. The upper data bits are ignored. Z and N update; C and V are kept.
- R9: Command 0x11 rotates A left by data[4:0]. A count of 0 leaves A unchanged. Z and N update; C and V are kept.
- R10: Commands 0x12 and 0x14 set A to the unsigned minimum and maximum of A and R. Commands 0x13 and 0x15 set A to the signed minimum and maximum. Z and N update; C and V are kept.
- R11: Command 0x08 sets C to data[0] and leaves A, Z, N and V unchanged.
- R12: Command 0x16 shifts A left by 8 bits and places the data byte in A[7:0]. Z and N update.
- R13: Read address 0 returns {4'b0, N, V, Z, C}. Read addresses 1 to 4 return A bytes 0 (least significant) to 3. Other read addresses return 0.
- R14: A write with a command code above 0x16 changes neither A nor the flags. Cycles with no write change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Command write strobe, one command per cycle |
| wr_cmd | input | 6 | Command address |
| wr_data | input | 8 | Register index, literal or ignored byte |
| rd_addr | input | 3 | Read select: status or an accumulator byte |
| rd_data | output | 8 | Combinational read data |

## Verification
Each command finishes in one clock, so a wrong accumulator or flag state is visible at the read port in the cycle right after the write edge. A register file entry that is written wrongly stays hidden until a later load or swap brings it back into A. For that reason the stimulus stores values, then loads or swaps them again, and it compares A and the status byte after every single command rather than only at the end of a sequence. Carry faults would otherwise stay latent, so carry-in chains (add with carry, subtract with borrow) run directly after commands that set or clear C.

// File: rtl/cop_pkg.sv
package cop_pkg;
  localparam int DATA_W = 32;
  localparam int CMD_W  = 6;
  localparam int BYTE_W = 8;

  typedef enum logic [CMD_W-1:0] {
    CMD_LOAD  = 6'h00, CMD_STORE = 6'h01, CMD_SWAP  = 6'h02,
    CMD_ADD   = 6'h03, CMD_ADDC  = 6'h04, CMD_SUB   = 6'h05,
    CMD_SUBB  = 6'h06, CMD_RSUB  = 6'h07, CMD_SETC  = 6'h08,
    CMD_CMP   = 6'h09, CMD_NEG   = 6'h0A, CMD_AND   = 6'h0B,
    CMD_OR    = 6'h0C, CMD_XOR   = 6'h0D, CMD_SHL   = 6'h0E,
    CMD_SHR   = 6'h0F, CMD_SAR   = 6'h10, CMD_ROL   = 6'h11,
    CMD_UMIN  = 6'h12, CMD_SMIN  = 6'h13, CMD_UMAX  = 6'h14,
    CMD_SMAX  = 6'h15, CMD_PUSHB = 6'h16
  } cmd_e;

  localparam logic [CMD_W-1:0] CMD_LAST = 6'h16;
endpackage

// File: rtl/cop_regfile.sv
module cop_regfile #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/cop_alu.sv
module cop_alu
  import cop_pkg::*;
#(
  parameter int W = DATA_W,
  localparam int SH_W = $clog2(W)
) (
  input  logic [CMD_W-1:0]  cmd,
  input  logic [BYTE_W-1:0] lit,
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      r,
  input  logic              c_in,
  output logic [W-1:0]      res,
  output logic              c_out,
  output logic              v_out,
  output logic              upd_acc,
  output logic              upd_cv,
  output logic              upd_c_only,
  output logic              upd_zn,
  output logic              wr_reg
);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic [SH_W-1:0] sh;
  logic [2*W-1:0]  rot;
  logic [W:0]      sum;
  logic [W-1:0]    opx, opy;
  logic            cin;

  assign sh  = lit[SH_W-1:0];
  assign rot = {a, a} << sh;

  always_comb begin
    opx = a;
    opy = r;
    cin = 1'b0;
    unique case (cmd)
      CMD_ADDC:                   cin = c_in;
      CMD_SUB, CMD_CMP: begin opy = ~r; cin = 1'b1; end
      CMD_SUBB:         begin opy = ~r; cin = c_in; end
      CMD_RSUB:         begin opx = r;  opy = ~a; cin = 1'b1; end
      default: ;
    endcase
  end

  assign sum = {1'b0, opx} + {1'b0, opy} + {{W{1'b0}}, cin};

  always_comb begin
    res        = a;
    c_out      = c_in;
    v_out      = 1'b0;
    upd_acc    = 1'b0;
    upd_cv     = 1'b0;
    upd_c_only = 1'b0;
    upd_zn     = 1'b0;
    wr_reg     = 1'b0;
    unique case (cmd)
      CMD_LOAD:  begin res = r; upd_acc = 1'b1; upd_zn = 1'b1; end
      CMD_STORE: wr_reg = 1'b1;
      CMD_SWAP:  begin res = r; upd_acc = 1'b1; upd_zn = 1'b1; wr_reg = 1'b1; end
      CMD_ADD, CMD_ADDC, CMD_SUB, CMD_SUBB, CMD_RSUB, CMD_CMP: begin
        res     = sum[W-1:0];
        c_out   = sum[W];
        v_out   = (opx[W-1] == opy[W-1]) && (sum[W-1] != opx[W-1]);
        upd_acc = (cmd != CMD_CMP);
        upd_cv  = 1'b1;
        upd_zn  = 1'b1;
      end
      CMD_SETC:  begin c_out = lit[0]; upd_c_only = 1'b1; end
      CMD_NEG: begin
        res     = -a;
        c_out   = (a != '0);
        v_out   = (a == MIN_NEG);
        upd_acc = 1'b1; upd_cv = 1'b1; upd_zn = 1'b1;
      end
      CMD_AND:   begin res = a & r;                  upd_acc = 1'b1; upd_zn = 1'b1; end
      CMD_OR:    begin res = a | r;                  upd_acc = 1'b1; upd_zn = 1'b1; end
      CMD_XOR:   begin res = a ^ r;                  upd_acc = 1'b1; upd_zn = 1'b1; end
      CMD_SHL:   begin res = a << sh;                upd_acc = 1'b1; upd_zn = 1'b1; end
      CMD_SHR:   begin res = a >> sh;                upd_acc = 1'b1; upd_zn = 1'b1; end
      CMD_SAR:   begin res = W'($signed(a) >>> sh);  upd_acc = 1'b1; upd_zn = 1'b1; end
      CMD_ROL:   begin res = rot[2*W-1:W];           upd_acc = 1'b1; upd_zn = 1'b1; end
      CMD_UMIN:  begin res = (a < r) ? a : r;        upd_acc = 1'b1; upd_zn = 1'b1; end
      CMD_UMAX:  begin res = (a > r) ? a : r;        upd_acc = 1'b1; upd_zn = 1'b1; end
      CMD_SMIN:  begin res = ($signed(a) < $signed(r)) ? a : r; upd_acc = 1'b1; upd_zn = 1'b1; end
      CMD_SMAX:  begin res = ($signed(a) > $signed(r)) ? a : r; upd_acc = 1'b1; upd_zn = 1'b1; end
      CMD_PUSHB: begin res = {a[W-BYTE_W-1:0], lit}; upd_acc = 1'b1; upd_zn = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/int_accum_cop.sv
module int_accum_cop
  import cop_pkg::*;
#(
  parameter int REGS = 256,
  parameter int W    = DATA_W,
  localparam int IDX_W = $clog2(REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CMD_W-1:0]  wr_cmd,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  logic [1:0]   rst_pipe;
  logic         rst_sync_n;
  logic [W-1:0] acc_q, acc_d;
  logic         c_q, v_q, z_q, n_q;
  logic         c_d, v_d, z_d, n_d;
  logic [W-1:0] reg_rd, alu_res;
  logic         alu_c, alu_v;
  logic         upd_acc, upd_cv, upd_c_only, upd_zn, wr_reg;
  logic         acc_en, flag_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  cop_regfile #(.WIDTH(W), .DEPTH(REGS)) u_rf (
    .clk   (clk),
    .we    (wr_en & wr_reg),
    .addr  (wr_data[IDX_W-1:0]),
    .wdata (acc_q),
    .rdata (reg_rd)
  );

  cop_alu #(.W(W)) u_alu (
    .cmd        (wr_cmd),
    .lit        (wr_data),
    .a          (acc_q),
    .r          (reg_rd),
    .c_in       (c_q),
    .res        (alu_res),
    .c_out      (alu_c),
    .v_out      (alu_v),
    .upd_acc    (upd_acc),
    .upd_cv     (upd_cv),
    .upd_c_only (upd_c_only),
    .upd_zn     (upd_zn),
    .wr_reg     (wr_reg)
  );

  assign acc_en  = wr_en & upd_acc;
  assign flag_en = wr_en & (upd_cv | upd_c_only | upd_zn);

  always_comb begin
    acc_d = acc_en ? alu_res : acc_q;
    c_d   = (upd_cv | upd_c_only) ? alu_c : c_q;
    v_d   = upd_cv ? alu_v : v_q;
    z_d   = upd_zn ? (alu_res == '0) : z_q;
    n_d   = upd_zn ? alu_res[W-1] : n_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  acc_q <= '0;
    else if (acc_en)  acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      c_q <= 1'b0; v_q <= 1'b0; z_q <= 1'b0; n_q <= 1'b0;
    end else if (flag_en) begin
      c_q <= c_d; v_q <= v_d; z_q <= z_d; n_q <= n_d;
    end
  end

  always_comb begin
    unique case (rd_addr)
      3'd0:    rd_data = {4'b0, n_q, v_q, z_q, c_q};
      3'd1:    rd_data = acc_q[7:0];
      3'd2:    rd_data = acc_q[15:8];
      3'd3:    rd_data = acc_q[23:16];
      3'd4:    rd_data = acc_q[31:24];
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cop_checker.sv
module cop_checker
  import cop_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [CMD_W-1:0]  wr_cmd,
  input logic [BYTE_W-1:0] wr_data,
  input logic [31:0]       acc,
  input logic              c,
  input logic              v,
  input logic              z,
  input logic              n
);
  logic zn_from_acc;
  logic logic_op;

  always_comb begin
    zn_from_acc = wr_cmd inside {CMD_LOAD, CMD_SWAP, CMD_ADD, CMD_ADDC, CMD_SUB,
                                 CMD_SUBB, CMD_RSUB, CMD_NEG, CMD_AND, CMD_OR,
                                 CMD_XOR, CMD_SHL, CMD_SHR, CMD_SAR, CMD_ROL,
                                 CMD_UMIN, CMD_SMIN, CMD_UMAX, CMD_SMAX, CMD_PUSHB};
    logic_op    = wr_cmd inside {CMD_AND, CMD_OR, CMD_XOR};
  end

  AST_STORE_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_cmd == CMD_STORE |=> $stable(acc)); // R2
  AST_ZN_FOLLOW_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && zn_from_acc |=> (z == (acc == 32'd0)) && (n == acc[31])); // R3
  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_cmd == CMD_CMP |=> $stable(acc)); // R5
  AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && logic_op |=> $stable(c) && $stable(v)); // R7
  AST_ROT_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_cmd == CMD_ROL && wr_data[4:0] == 5'd0 |=> $stable(acc)); // R9
  AST_SETC_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_cmd == CMD_SETC |=> c == $past(wr_data[0]) && $stable(acc)); // R11
  AST_PUSH_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_cmd == CMD_PUSHB |=> acc[7:0] == $past(wr_data) && acc[31:8] == $past(acc[23:0])); // R12
  AST_UNUSED_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_cmd > CMD_LAST) |=> $stable(acc) && $stable({n, v, z, c})); // R14
endmodule

bind int_accum_cop cop_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .wr_en   (wr_en),
  .wr_cmd  (wr_cmd),
  .wr_data (wr_data),
  .acc     (acc_q),
  .c       (c_q),
  .v       (v_q),
  .z       (z_q),
  .n       (n_q)
);

// File: tb/sim_int_accum_cop.sv
module sim_int_accum_cop;
  import cop_pkg::*;
  localparam int CLK_PERIOD = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [5:0] wr_cmd = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [31:0] acc;
    logic [3:0]  st;   // {N,V,Z,C}
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [31:0] m_acc;
  logic        m_c, m_v, m_z, m_n;
  logic [31:0] m_regs [256];

  int_accum_cop u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd),
                    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic read_all(output logic [31:0] acc, output logic [7:0] st);
    rd_addr = 3'd0; #1; st = rd_data;
    for (int i = 0; i < 4; i++) begin
      rd_addr = 3'(i + 1); #1; acc[8*i +: 8] = rd_data;
    end
  endtask

  function automatic void arith(input logic [31:0] x, input logic [31:0] y, input logic ci,
                                input bit keep_acc);
    logic [32:0] s;
    s = {1'b0, x} + {1'b0, y} + {32'd0, ci};
    m_c = s[32];
    m_v = (x[31] == y[31]) && (s[31] != x[31]);
    m_z = (s[31:0] == 0);
    m_n = s[31];
    if (!keep_acc) m_acc = s[31:0];
  endfunction

  function automatic void set_acc(input logic [31:0] x);
    m_acc = x; m_z = (x == 0); m_n = x[31];
  endfunction

  function automatic void model(input logic [5:0] op, input logic [7:0] d);
    logic [31:0] r;
    logic [4:0]  s;
    r = m_regs[d];
    s = d[4:0];
    case (op)
      CMD_LOAD:  set_acc(r);
      CMD_STORE: m_regs[d] = m_acc;
      CMD_SWAP:  begin m_regs[d] = m_acc; set_acc(r); end
      CMD_ADD:   arith(m_acc, r, 1'b0, 0);
      CMD_ADDC:  arith(m_acc, r, m_c, 0);
      CMD_SUB:   arith(m_acc, ~r, 1'b1, 0);
      CMD_SUBB:  arith(m_acc, ~r, m_c, 0);
      CMD_RSUB:  arith(r, ~m_acc, 1'b1, 0);
      CMD_CMP:   arith(m_acc, ~r, 1'b1, 1);
      CMD_SETC:  m_c = d[0];
      CMD_NEG:   begin m_c = (m_acc != 0); m_v = (m_acc == 32'h8000_0000); set_acc(0 - m_acc); end
      CMD_AND:   set_acc(m_acc & r);
      CMD_OR:    set_acc(m_acc | r);
      CMD_XOR:   set_acc(m_acc ^ r);
      CMD_SHL:   set_acc(m_acc << s);
      CMD_SHR:   set_acc(m_acc >> s);
      CMD_SAR:   set_acc(32'($signed(m_acc) >>> s));
      CMD_ROL:   set_acc(s == 0 ? m_acc : ((m_acc << s) | (m_acc >> (6'd32 - 6'(s)))));
      CMD_UMIN:  set_acc(m_acc < r ? m_acc : r);
      CMD_UMAX:  set_acc(m_acc > r ? m_acc : r);
      CMD_SMIN:  set_acc($signed(m_acc) < $signed(r) ? m_acc : r);
      CMD_SMAX:  set_acc($signed(m_acc) > $signed(r) ? m_acc : r);
      CMD_PUSHB: set_acc({m_acc[23:0], d});
      default: ;
    endcase
  endfunction

  // Driver: issues one command and pushes the expected outcome
  task automatic cmd(input logic [5:0] op, input logic [7:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = 1'b1; wr_cmd = op; wr_data = d;
    model(op, d);
    e.acc = m_acc; e.st = {m_n, m_v, m_z, m_c}; e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic push32(input logic [31:0] x, input string tag);
    for (int i = 3; i >= 0; i--) cmd(CMD_PUSHB, x[8*i +: 8], tag);
  endtask

  // Monitor: after each command edge, pop and compare the port-visible state
  always @(posedge clk) begin
    if (rst_n && wr_en) begin
      exp_t e;
      logic [31:0] acc;
      logic [7:0]  st;
      #2;
      read_all(acc, st);
      if (sb.size() == 0) begin
        checks++; failures++;
        $display("FAIL scoreboard empty actual=%08h expected=none", acc);
      end else begin
        e = sb.pop_front();
        check({e.tag, " acc"}, acc, e.acc);
        check({e.tag, " status"}, {24'd0, st}, {28'd0, e.st});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] acc;
    logic [7:0]  st;
    m_acc = 0; m_c = 0; m_v = 0; m_z = 0; m_n = 0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #3;
    read_all(acc, st);
    check("R1 reset acc", acc, 32'd0);
    check("R1 reset status", {24'd0, st}, 32'd0);
    rd_addr = 3'd7; #1;
    check("R13 unused read address", {24'd0, rd_data}, 32'd0);

    // seed constants
    push32(32'h7FFF_FFFF, "R12 push");
    cmd(CMD_STORE, 8'd5, "R2 store");
    push32(32'h0000_0001, "R12 push");
    cmd(CMD_STORE, 8'd6, "R2 store");
    push32(32'h0000_0000, "R12 push zero");
    cmd(CMD_STORE, 8'd7, "R2 store");
    push32(32'hFFFF_FFFF, "R12 push");
    cmd(CMD_STORE, 8'd200, "R2 store high index");
    push32(32'hF0F0_1234, "R12 push");
    cmd(CMD_STORE, 8'd9, "R2 store");

    // add / carry / overflow
    cmd(CMD_LOAD, 8'd5, "R2 load");
    cmd(CMD_ADD, 8'd6, "R3 add overflow");
    cmd(CMD_ADD, 8'd5, "R3 add");
    cmd(CMD_ADD, 8'd6, "R3 add carry zero");
    cmd(CMD_SETC, 8'd1, "R11 setc 1");
    cmd(CMD_ADDC, 8'd6, "R3 addc");
    cmd(CMD_SETC, 8'hFE, "R11 setc bit0 only");
    cmd(CMD_ADDC, 8'd6, "R3 addc no carry");
    // subtract family
    cmd(CMD_SUB, 8'd6, "R4 sub");
    cmd(CMD_SUB, 8'd5, "R4 sub borrow");
    cmd(CMD_SUBB, 8'd6, "R4 subb borrow in");
    cmd(CMD_SETC, 8'd1, "R11 setc 1");
    cmd(CMD_SUBB, 8'd6, "R4 subb no borrow");
    cmd(CMD_RSUB, 8'd6, "R4 rsub");
    cmd(CMD_CMP, 8'd200, "R5 cmp");
    cmd(CMD_CMP, 8'd5, "R5 cmp");
    // negate
    cmd(CMD_NEG, 8'd0, "R6 neg");
    cmd(CMD_LOAD, 8'd7, "R2 load zero");
    cmd(CMD_NEG, 8'd0, "R6 neg zero");
    push32(32'h8000_0000, "R12 push");
    cmd(CMD_NEG, 8'd0, "R6 neg min");
    // logic keeps C/V
    cmd(CMD_SETC, 8'd1, "R11 setc 1");
    cmd(CMD_LOAD, 8'd200, "R2 load");
    cmd(CMD_AND, 8'd9, "R7 and");
    cmd(CMD_OR, 8'd5, "R7 or");
    cmd(CMD_XOR, 8'd200, "R7 xor");
    cmd(CMD_AND, 8'd7, "R7 and zero");
    // shifts
    cmd(CMD_LOAD, 8'd9, "R2 load");
    cmd(CMD_SHL, 8'h24, "R8 shl upper bits ignored");
    cmd(CMD_LOAD, 8'd9, "R2 load");
    cmd(CMD_SHR, 8'd31, "R8 shr 31");
    cmd(CMD_LOAD, 8'd9, "R2 load");
    cmd(CMD_SAR, 8'd8, "R8 sar");
    cmd(CMD_SHR, 8'd0, "R8 shr 0");
    // rotate
    cmd(CMD_LOAD, 8'd9, "R2 load");
    cmd(CMD_ROL, 8'd0, "R9 rol 0");
    cmd(CMD_ROL, 8'h28, "R9 rol 8");
    cmd(CMD_ROL, 8'd31, "R9 rol 31");
    // min / max: -1 vs 1 differs signed vs unsigned
    cmd(CMD_LOAD, 8'd200, "R2 load");
    cmd(CMD_UMIN, 8'd6, "R10 umin");
    cmd(CMD_LOAD, 8'd200, "R2 load");
    cmd(CMD_SMIN, 8'd6, "R10 smin");
    cmd(CMD_LOAD, 8'd200, "R2 load");
    cmd(CMD_UMAX, 8'd6, "R10 umax");
    cmd(CMD_LOAD, 8'd200, "R2 load");
    cmd(CMD_SMAX, 8'd6, "R10 smax");
    // swap and read back both sides
    cmd(CMD_LOAD, 8'd9, "R2 load");
    cmd(CMD_SWAP, 8'd6, "R2 swap");
    cmd(CMD_LOAD, 8'd6, "R2 swapped reg");
    // unassigned codes do nothing
    cmd(6'h17, 8'd5, "R14 unused 0x17");
    cmd(6'h3F, 8'd200, "R14 unused 0x3F");
    cmd(CMD_LOAD, 8'd5, "R14 reg intact");
    repeat (4) @(posedge clk);
    #3;
    read_all(acc, st);
    check("R14 idle acc", acc, m_acc);
    check("R13 status layout", {24'd0, st}, {28'd0, m_n, m_v, m_z, m_c});
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule